// File: doc/BRIEF.md
# Triple-Oversampled Asynchronous Serial Receiver

This block receives 8-N-1 asynchronous characters. It samples the serial line on a sample tick that runs at three times the baud rate. A falling edge on the line, seen between two consecutive ticks, acts as the frame trigger. From that sample on, the block collects a fixed window of 29 samples: three for the start bit, three for each of the eight data bits, and only two for the stop bit. Each data bit is the centre sample of its group of three.

Because the window ends one sample early, the receiver is already watching for the next falling edge during the last third of the stop bit. A sender whose clock runs slightly fast, and whose next start bit therefore arrives about a third of a bit early, stays in sync. Recovered bytes go into an eight-entry FIFO that the host reads with a single-cycle read strobe. The FIFO has sticky flags for overflow and underflow. Integration needs only the serial line, an enable, and a divider value that sets the tick period.

Top module: `osr_uart_rx`

## Requirements
- R1: The sample tick period is 2*(div+1) clock cycles. A character sent with a bit time of 6*(div+1) clocks is received correctly for div=1 and for div=2.
- R2: A frame begins only at a tick where the synchronized line is 0 and the previous tick saw 1. A line held low from the moment of enabling starts no frame and pushes no byte.
- R3: Data bits arrive least significant first. Data bit k is taken from sample index 4+3k of the frame, where index 0 is the triggering sample. The byte is pushed whatever the stop-bit level.
- R4: A frame is exactly 29 samples long. Edge detection re-arms straight after the 29th sample, so a start bit that follows a stop bit shortened to two thirds of a bit time is still received.
- R5: The FIFO holds 8 bytes in arrival order. rd_data shows the oldest unread byte, and a cycle with rd_en high while not empty removes it.
- R6: not_empty is 1 exactly while the FIFO holds at least one unread byte. It is 0 after reset.
- R7: A byte completed while the FIFO holds 8 bytes and no read happens in that cycle is discarded. It sets ovf to 1, and ovf then stays 1 until reset. The 8 stored bytes are kept.
- R8: rd_en while the FIFO is empty sets unf to 1, which stays 1 until reset. It leaves the FIFO empty.
- R9: While en is 0, no ticks occur and any partly collected frame is dropped without pushing a byte. After re-enabling, the next full character is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receiver enable; 0 holds the receiver idle |
| div | input | DIV_W | Tick divider; tick period is 2*(div+1) clocks |
| rx | input | 1 | Asynchronous serial line, idle high |
| rd_en | input | 1 | Read strobe, pops the oldest byte |
| rd_data | output | 8 | Oldest unread byte |
| not_empty | output | 1 | FIFO holds unread data |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |

## Verification
The embedded properties watch, on every cycle, the structural invariants. Ticks are never back to back and stop when disabled. The sample index stays inside the frame, and a completed byte only follows an active capture. Disabling forces idle. The FIFO never counts past its depth, and both error flags are sticky. Only the directed scenarios can show the rest. That covers the correct bit positions, least-significant-first order and the tick period at two divider values. It also covers acceptance of an early start bit after a shortened stop bit, dropping the ninth byte on overflow, and rejection of a line held low at enable.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;
    localparam int OSR       = 3;
    localparam int DATA_BITS = 8;
    localparam int STOP_SMP  = 2;
    localparam int FRAME_LEN = OSR + OSR * DATA_BITS + STOP_SMP;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int MID_OFS   = 1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CAP  = 1'b1
    } cap_st_e;
endpackage

// File: rtl/osr_rx_tick.sv
module osr_rx_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CW = DIV_W + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_t;

    tick_t cur_q, nxt_d;
    logic [CW-1:0] limit;

    always_comb begin
        limit = {div, 1'b1};
        nxt_d = cur_q;
        nxt_d.tick = 1'b0;
        if (!en) begin
            nxt_d.cnt = '0;
        end else if (cur_q.cnt == limit) begin
            nxt_d.cnt  = '0;
            nxt_d.tick = 1'b1;
        end else begin
            nxt_d.cnt = cur_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign tick = cur_q.tick;

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R9
    tick_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick);
endmodule

// File: rtl/osr_rx_frame.sv
module osr_rx_frame
    import osr_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 tick,
    input  logic                 rx,
    output logic                 done,
    output logic [DATA_BITS-1:0] data
);
    typedef struct packed {
        logic                 sync1;
        logic                 sync2;
        logic                 prev;
        cap_st_e              st;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_LEN-1:0] shreg;
        logic                 done;
        logic [DATA_BITS-1:0] data;
    } frm_t;

    localparam frm_t FRM_RST = '{sync1: 1'b1, sync2: 1'b1, prev: 1'b0,
                                 st: ST_IDLE, idx: '0, shreg: '1,
                                 done: 1'b0, data: '0};

    frm_t cur_q, nxt_d;
    logic smp;
    logic [FRAME_LEN-1:0] shifted;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.sync1 = rx;
        nxt_d.sync2 = cur_q.sync1;
        nxt_d.done  = 1'b0;
        smp         = cur_q.sync2;
        shifted     = {smp, cur_q.shreg[FRAME_LEN-1:1]};
        if (!en) begin
            nxt_d.st   = ST_IDLE;
            nxt_d.idx  = '0;
            nxt_d.prev = 1'b0;
        end else if (tick) begin
            nxt_d.prev = smp;
            unique case (cur_q.st)
                ST_IDLE: begin
                    if (cur_q.prev && !smp) begin
                        nxt_d.st    = ST_CAP;
                        nxt_d.idx   = IDX_W'(1);
                        nxt_d.shreg = shifted;
                    end
                end
                ST_CAP: begin
                    nxt_d.shreg = shifted;
                    if (cur_q.idx == IDX_W'(FRAME_LEN - 1)) begin
                        nxt_d.st   = ST_IDLE;
                        nxt_d.idx  = '0;
                        nxt_d.done = 1'b1;
                        for (int k = 0; k < DATA_BITS; k++) begin
                            nxt_d.data[k] = shifted[OSR + OSR * k + MID_OFS];
                        end
                    end else begin
                        nxt_d.idx = cur_q.idx + IDX_W'(1);
                    end
                end
                default: nxt_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= FRM_RST;
        else        cur_q <= nxt_d;
    end

    assign done = cur_q.done;
    assign data = cur_q.data;

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cur_q.st == ST_IDLE) && !done);
    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.idx < IDX_W'(FRAME_LEN));
    // R4
    done_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cur_q.st == ST_CAP) && $past(tick));
endmodule

// File: rtl/osr_rx_fifo.sv
module osr_rx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         not_empty,
    output logic         ovf,
    output logic         unf
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
        logic                    ovf;
        logic                    unf;
    } fifo_t;

    fifo_t cur_q, nxt_d;
    logic do_pop, do_push, full, empty;

    always_comb begin
        nxt_d   = cur_q;
        empty   = (cur_q.cnt == '0);
        full    = (cur_q.cnt == CW'(DEPTH));
        do_pop  = rd_en && !empty;
        do_push = push && (!full || do_pop);
        if (do_push) begin
            nxt_d.mem[cur_q.wp] = push_data;
            nxt_d.wp            = cur_q.wp + AW'(1);
        end
        if (do_pop) nxt_d.rp = cur_q.rp + AW'(1);
        nxt_d.cnt = cur_q.cnt + CW'(do_push) - CW'(do_pop);
        if (push && full && !do_pop) nxt_d.ovf = 1'b1;
        if (rd_en && empty)          nxt_d.unf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rd_data   = cur_q.mem[cur_q.rp];
    assign not_empty = (cur_q.cnt != '0);
    assign ovf       = cur_q.ovf;
    assign unf       = cur_q.unf;

    // R5
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= CW'(DEPTH));
    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    // R8
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> unf);
    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!not_empty && rd_en && !push) |=> !not_empty && unf);
endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
    import osr_rx_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             rx,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             not_empty,
    output logic             ovf,
    output logic             unf
);
    logic                 tick;
    logic                 frm_done;
    logic [DATA_BITS-1:0] frm_data;

    osr_rx_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .div   (div),
        .tick  (tick)
    );

    osr_rx_frame u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .tick  (tick),
        .rx    (rx),
        .done  (frm_done),
        .data  (frm_data)
    );

    osr_rx_fifo #(.DEPTH(DEPTH), .W(DATA_BITS)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (frm_done),
        .push_data (frm_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .not_empty (not_empty),
        .ovf       (ovf),
        .unf       (unf)
    );
endmodule

// File: tb/tb_osr_uart_rx.sv
module tb_osr_uart_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] div = 8'd1;
    logic       rx = 1'b1;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       not_empty, ovf, unf;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    osr_uart_rx dut (
        .clk(clk), .rst_n(rst_n), .en(en), .div(div), .rx(rx),
        .rd_en(rd_en), .rd_data(rd_data), .not_empty(not_empty),
        .ovf(ovf), .unf(unf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int bitc();
        return 6 * (int'(div) + 1);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int stop_clks);
        rx = 1'b0; idle(bitc());
        for (int k = 0; k < 8; k++) begin
            rx = b[k]; idle(bitc());
        end
        rx = 1'b1; idle(stop_clks);
    endtask

    task automatic pop_expect(input logic [7:0] exp, input string req);
        @(negedge clk);
        chk(not_empty == 1'b1, req, int'(not_empty), 1);
        chk(rd_data == exp, req, int'(rd_data), int'(exp));
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic restart(input logic [7:0] d);
        en = 1'b0; div = d; idle(4); en = 1'b1; idle(3 * bitc());
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(not_empty == 1'b0, "R6 reset not_empty", int'(not_empty), 0);
        chk(ovf == 1'b0, "R7 reset ovf", int'(ovf), 0);
        chk(unf == 1'b0, "R8 reset unf", int'(unf), 0);
    endtask

    task automatic t_low_at_enable();
        en = 1'b0; rx = 1'b0; idle(4); en = 1'b1;
        idle(12 * bitc());
        chk(not_empty == 1'b0, "R2 low line at enable", int'(not_empty), 0);
        rx = 1'b1; idle(3 * bitc());
        chk(not_empty == 1'b0, "R2 rising line alone", int'(not_empty), 0);
    endtask

    task automatic t_basic();
        send_byte(8'h55, bitc());
        send_byte(8'hA3, bitc());
        idle(4);
        pop_expect(8'h55, "R3 R5 first byte");
        pop_expect(8'hA3, "R3 R5 second byte");
        @(negedge clk);
        chk(not_empty == 1'b0, "R6 drained", int'(not_empty), 0);
        send_byte(8'h00, bitc());
        send_byte(8'hFF, bitc());
        idle(4);
        pop_expect(8'h00, "R3 all zero");
        pop_expect(8'hFF, "R3 all one");
    endtask

    task automatic t_div2();
        restart(8'd2);
        send_byte(8'h3C, bitc());
        send_byte(8'hC1, bitc());
        idle(4);
        pop_expect(8'h3C, "R1 div2 first");
        pop_expect(8'hC1, "R1 div2 second");
        restart(8'd1);
    endtask

    task automatic t_early();
        send_byte(8'h81, (2 * bitc()) / 3);
        send_byte(8'h4A, (2 * bitc()) / 3);
        send_byte(8'hB6, bitc());
        idle(4);
        pop_expect(8'h81, "R4 before short stop");
        pop_expect(8'h4A, "R4 early start accepted");
        pop_expect(8'hB6, "R4 sync kept");
        @(negedge clk);
        chk(not_empty == 1'b0, "R4 no extra byte", int'(not_empty), 0);
    endtask

    task automatic t_abort();
        rx = 1'b0; idle(bitc());
        rx = 1'b1; idle(bitc());
        rx = 1'b0; idle(bitc() / 2);
        en = 1'b0; rx = 1'b1; idle(3 * bitc());
        en = 1'b1; idle(12 * bitc());
        chk(not_empty == 1'b0, "R9 partial frame dropped", int'(not_empty), 0);
        send_byte(8'h96, bitc());
        idle(4);
        pop_expect(8'h96, "R9 recovery after abort");
    endtask

    task automatic t_underflow();
        @(negedge clk);
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        @(negedge clk);
        chk(unf == 1'b1, "R8 unf set", int'(unf), 1);
        chk(not_empty == 1'b0, "R8 still empty", int'(not_empty), 0);
        chk(ovf == 1'b0, "R7 ovf clear before overflow", int'(ovf), 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 9; i++) send_byte(8'(8'h10 + i * 7), bitc());
        idle(4);
        chk(ovf == 1'b1, "R7 ovf set", int'(ovf), 1);
        for (int i = 0; i < 8; i++) pop_expect(8'(8'h10 + i * 7), "R7 kept bytes");
        @(negedge clk);
        chk(not_empty == 1'b0, "R7 ninth byte dropped", int'(not_empty), 0);
        chk(ovf == 1'b1, "R7 ovf sticky", int'(ovf), 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        en = 1'b1; idle(3 * bitc());
        t_low_at_enable();
        t_basic();
        t_div2();
        t_early();
        t_abort();
        t_underflow();
        t_overflow();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule